// File: doc/BRIEF.md
# Time-of-Day Counter with Trimmed and Fixed-Step Advance

This block keeps a seconds and nanoseconds time of day for network time stamping. It runs on a reference clock and can advance in one of two ways. In trimmed mode, a phase accumulator adds a programmable addend on every cycle. The time moves forward by a programmable nanosecond step only on cycles where that sum carries out of the accumulator. Software tunes the rate by rewriting the addend. In fixed-step mode, the accumulator sits idle and the step is added on every enabled cycle. This gives twice the resolution of the usual trimmed setup, but the rate cannot be tuned.

Software reaches the block through a single-cycle write port. That port sets the step, the addend, the mode, a run enable, and a staged seconds value. A write of a nanoseconds value loads a new time at once, which is how software steps the offset. The mode and the step are locked while the counter runs, so a switch between the two modes has to pass through a stopped state.

Top module: `ptp_time_counter`

## Requirements
- R1: After synchronous reset, seconds and nanoseconds read zero, the accumulator, addend and step are zero, the counter is stopped and the mode is trimmed.
- R2: In fixed-step mode with the counter running, nanoseconds grow by the step on every cycle, and the accumulator keeps its value.
- R3: In trimmed mode with the counter running, the addend is added to the 32-bit accumulator on every cycle. The time grows by the step only on a cycle where the addition carries out of bit 31.
- R4: A larger addend produces carries more often. A new addend is used from the first cycle after its write, without clearing the accumulator. For example, with addend 0x4000_0000 there is one carry every 4 cycles, and with 0xC000_0000 there are 3 carries every 4 cycles.
- R5: When an advance brings nanoseconds to 1,000,000,000 or more, nanoseconds keep the amount above 1,000,000,000 and seconds increase by one.
- R6: While the run enable is low, seconds, nanoseconds and the accumulator hold their values.
- R7: Writes to the mode bit and to the step register are ignored while the counter is running. A control write that stops the counter still cannot change the mode in that same write.
- R8: A write to address 4 loads nanoseconds from write data bits 29:0 and seconds from the staged seconds register. The same write clears the accumulator. It takes priority over that cycle's advance and works whether or not the counter runs.
- R9: Register map, write only: address 0 is control, with bit 0 as run enable and bit 1 as mode (1 = fixed-step, 0 = trimmed). Address 1 is the step in whole nanoseconds (bits 7:0). Address 2 is the 32-bit addend. Address 3 is the staged seconds. Address 4 is the nanoseconds load. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| sec_out | output | 32 | Seconds of the time of day |
| ns_out | output | 30 | Nanoseconds of the time of day, below 1e9 for valid loads |

## Verification
The bench builds the block with its default parameters: 32-bit seconds, 30-bit nanoseconds, an 8-bit step and a 32-bit accumulator with a nanosecond limit of one billion. With these values, addends that are simple binary fractions give exact carry rates over short windows, so tick counts can be checked directly. A load a few nanoseconds below the limit reaches the rollover of seconds within one step. A behavioural model using wide integers follows every write and is compared on each cycle. This covers random addend rewrites, as well as start and stop sequences in both modes.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_STEP   = 3'd1,
        REG_ADDEND = 3'd2,
        REG_SEC    = 3'd3,
        REG_NSLOAD = 3'd4
    } reg_addr_e;

    typedef enum logic {
        ADV_TRIMMED = 1'b0,
        ADV_FIXED   = 1'b1
    } adv_mode_e;

    typedef struct packed {
        adv_mode_e mode;
        logic      run;
    } ctrl_t;

    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;

    function automatic logic is_fixed(input ctrl_t c);
        return c.mode == ADV_FIXED;
    endfunction

endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
    import ptp_tc_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STEP_W = 8,
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [STEP_W-1:0] step,
    output logic [ACC_W-1:0]  addend,
    output logic [SEC_W-1:0]  sec_stage,
    output logic              load
);

    ctrl_t             ctrl_q;
    logic [STEP_W-1:0] step_q;
    logic [ACC_W-1:0]  addend_q;
    logic [SEC_W-1:0]  stage_q;

    // Locked fields may only change while the counter is stopped.
    logic unlocked;
    assign unlocked = !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '{mode: ADV_TRIMMED, run: 1'b0};
            step_q   <= '0;
            addend_q <= '0;
            stage_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    ctrl_q.run <= wr_data[CTRL_RUN_BIT];
                    if (unlocked)
                        ctrl_q.mode <= adv_mode_e'(wr_data[CTRL_MODE_BIT]);
                end
                REG_STEP: begin
                    if (unlocked)
                        step_q <= wr_data[STEP_W-1:0];
                end
                REG_ADDEND: addend_q <= wr_data[ACC_W-1:0];
                REG_SEC:    stage_q  <= wr_data[SEC_W-1:0];
                default: ;
            endcase
        end
    end

    assign ctrl      = ctrl_q;
    assign step      = step_q;
    assign addend    = addend_q;
    assign sec_stage = stage_q;
    assign load      = wr_en && (wr_addr == REG_NSLOAD);

endmodule

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [ACC_W-1:0] addend,
    output logic             carry,
    output logic [ACC_W-1:0] acc
);

    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_q;

    assign sum   = {1'b0, acc_q} + {1'b0, addend};
    assign carry = run && sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc_q <= '0;
        else if (run)
            acc_q <= sum[ACC_W-1:0];
    end

    assign acc = acc_q;

endmodule

// File: rtl/ptp_tod.sv
module ptp_tod #(
    parameter int unsigned SEC_W    = 32,
    parameter int unsigned NS_W     = 30,
    parameter int unsigned STEP_W   = 8,
    parameter int unsigned NS_LIMIT = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [STEP_W-1:0] step,
    input  logic              load,
    input  logic [SEC_W-1:0]  load_sec,
    input  logic [NS_W-1:0]   load_ns,
    output logic [SEC_W-1:0]  sec,
    output logic [NS_W-1:0]   ns
);

    localparam logic [NS_W:0] LIMIT_V = (NS_W+1)'(NS_LIMIT);

    logic [SEC_W-1:0] sec_q;
    logic [NS_W-1:0]  ns_q;
    logic [NS_W:0]    ns_sum;
    logic [NS_W:0]    ns_over;
    logic             rolls;

    always_comb begin
        ns_sum  = {1'b0, ns_q} + (NS_W+1)'(step);
        rolls   = ns_sum >= LIMIT_V;
        ns_over = ns_sum - LIMIT_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (load) begin
            sec_q <= load_sec;
            ns_q  <= load_ns;
        end else if (advance) begin
            if (rolls) begin
                ns_q  <= ns_over[NS_W-1:0];
                sec_q <= sec_q + SEC_W'(1);
            end else begin
                ns_q  <= ns_sum[NS_W-1:0];
            end
        end
    end

    assign sec = sec_q;
    assign ns  = ns_q;

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SEC_W    = 32,
    parameter int unsigned NS_W     = 30,
    parameter int unsigned STEP_W   = 8,
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned NS_LIMIT = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEC_W-1:0]  sec_out,
    output logic [NS_W-1:0]   ns_out
);

    ctrl_t             ctrl;
    logic [STEP_W-1:0] step;
    logic [ACC_W-1:0]  addend;
    logic [SEC_W-1:0]  sec_stage;
    logic              load;
    logic              carry;
    logic [ACC_W-1:0]  acc;
    logic              run_en;
    logic              fixed;
    logic              advance;

    ptp_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W),
        .ACC_W(ACC_W), .SEC_W(SEC_W)
    ) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .step(step), .addend(addend),
        .sec_stage(sec_stage), .load(load)
    );

    assign run_en = ctrl.run;
    assign fixed  = is_fixed(ctrl);

    ptp_phase_acc #(.ACC_W(ACC_W)) i_acc (
        .clk(clk), .rst(rst), .run(run_en && !fixed), .clear(load),
        .addend(addend), .carry(carry), .acc(acc)
    );

    assign advance = run_en && (fixed || carry);

    ptp_tod #(
        .SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .NS_LIMIT(NS_LIMIT)
    ) i_tod (
        .clk(clk), .rst(rst), .advance(advance), .step(step),
        .load(load), .load_sec(sec_stage), .load_ns(wr_data[NS_W-1:0]),
        .sec(sec_out), .ns(ns_out)
    );

endmodule

// File: rtl/ptp_tc_checker.sv
module ptp_tc_checker #(
    parameter int unsigned SEC_W    = 32,
    parameter int unsigned NS_W     = 30,
    parameter int unsigned STEP_W   = 8,
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned NS_LIMIT = 1_000_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr,
    input logic              step_wr,
    input logic              run_en,
    input logic              fixed,
    input logic [STEP_W-1:0] step,
    input logic              load,
    input logic [NS_W-1:0]   load_ns,
    input logic [ACC_W-1:0]  acc,
    input logic [SEC_W-1:0]  sec,
    input logic [NS_W-1:0]   ns
);

    localparam logic [NS_W:0] LIMIT_V = (NS_W+1)'(NS_LIMIT);

    logic [NS_W:0] nxt;
    assign nxt = {1'b0, ns} + (NS_W+1)'(step);

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !load) |=> (sec == $past(sec) && ns == $past(ns) && acc == $past(acc))); // R6

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (run_en && ctrl_wr) |=> (fixed == $past(fixed))); // R7

    AST_STEP_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (run_en && step_wr) |=> (step == $past(step))); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (ns == $past(load_ns) && acc == '0)); // R8

    AST_SEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !load |=> (sec == $past(sec) || sec == $past(sec) + SEC_W'(1))); // R5

    AST_FIXED_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fixed && !load) |=> (acc == $past(acc))); // R2

    AST_FIXED_STEP: assert property (@(posedge clk) disable iff (rst)
        (run_en && fixed && !load && nxt < LIMIT_V) |=> (ns == $past(nxt[NS_W-1:0]))); // R2

endmodule

bind ptp_time_counter ptp_tc_checker #(
    .SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W), .ACC_W(ACC_W), .NS_LIMIT(NS_LIMIT)
) i_chk (
    .clk(clk), .rst(rst),
    .ctrl_wr(wr_en && wr_addr == 3'd0),
    .step_wr(wr_en && wr_addr == 3'd1),
    .run_en(run_en), .fixed(fixed), .step(step), .load(load),
    .load_ns(wr_data[NS_W-1:0]), .acc(acc), .sec(sec_out), .ns(ns_out)
);

// File: tb/test_ptp_time_counter.sv
module test_ptp_time_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] sec_out;
    logic [29:0] ns_out;

    int    total = 0;
    int    bad = 0;
    bit    started = 0;
    string cur_req = "R1";

    // behavioural reference
    longint unsigned m_sec, m_ns, m_acc, m_add, m_step, m_stage;
    bit m_run, m_fixed;

    always #4 clk = ~clk;

    ptp_time_counter i_ptp_time_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sec_out(sec_out), .ns_out(ns_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_ns = 0; m_acc = 0; m_add = 0; m_step = 0; m_stage = 0;
            m_run = 0; m_fixed = 0;
        end else begin
            bit old_run;
            bit adv;
            old_run = m_run;
            if (wr_en && wr_addr == 3'd4) begin
                m_sec = m_stage;
                m_ns  = longint'(wr_data[29:0]);
                m_acc = 0;
            end else if (m_run) begin
                adv = 1;
                if (!m_fixed) begin
                    m_acc = m_acc + m_add;
                    adv   = (m_acc >= 64'h1_0000_0000);
                    m_acc = m_acc % 64'h1_0000_0000;
                end
                if (adv) begin
                    m_ns = m_ns + m_step;
                    if (m_ns >= 1_000_000_000) begin
                        m_ns  = m_ns - 1_000_000_000;
                        m_sec = (m_sec + 1) % 64'h1_0000_0000;
                    end
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        if (!old_run) m_fixed = wr_data[1];
                        m_run = wr_data[0];
                    end
                    3'd1: if (!old_run) m_step = longint'(wr_data[7:0]);
                    3'd2: m_add = longint'(wr_data);
                    3'd3: m_stage = longint'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            chk({cur_req, " ns vs model"}, longint'(ns_out), m_ns);
            chk({cur_req, " sec vs model"}, longint'(sec_out), m_sec);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_addr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint unsigned t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ns", ns_out, 0);
        chk("R1 sec", sec_out, 0);
        idle(3);
        chk("R1 stopped", ns_out, 0);

        // R2 / R9: fixed-step mode, step 4
        cur_req = "R2";
        wr(3'd1, 32'd4);
        wr(3'd0, 32'd3);
        chk("R2 start", ns_out, 0);
        idle(5);
        chk("R2 five steps", ns_out, 20);

        // R7: locked writes while running
        cur_req = "R7";
        wr(3'd1, 32'd9);
        wr(3'd0, 32'd1);
        t0 = ns_out;
        idle(5);
        chk("R7 step and mode kept", ns_out, t0 + 20);

        // R6: stop holds time
        cur_req = "R6";
        wr(3'd0, 32'd2);
        t0 = ns_out;
        idle(5);
        chk("R6 hold", ns_out, t0);

        // R3: trimmed mode, one carry every 2 cycles
        cur_req = "R3";
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd8);
        wr(3'd2, 32'h8000_0000);
        wr(3'd0, 32'd1);
        t0 = ns_out;
        idle(10);
        chk("R3 half rate", ns_out, t0 + 40);

        // R4: addend changes rate
        cur_req = "R4";
        wr(3'd2, 32'h4000_0000);
        t0 = ns_out;
        idle(16);
        chk("R4 quarter rate", ns_out, t0 + 32);
        wr(3'd2, 32'hC000_0000);
        t0 = ns_out;
        idle(16);
        chk("R4 three quarter rate", ns_out, t0 + 96);

        // R8: load while running
        cur_req = "R8";
        wr(3'd3, 32'd7);
        wr(3'd4, 32'd999_999_990);
        chk("R8 ns loaded", ns_out, 999_999_990);
        chk("R8 sec loaded", sec_out, 7);
        idle(4);

        // R5: rollover in fixed mode
        cur_req = "R5";
        wr(3'd0, 32'd0);
        wr(3'd0, 32'd3);
        wr(3'd4, 32'd999_999_995);
        @(negedge clk);
        chk("R5 ns wrap", ns_out, 3);
        chk("R5 sec carry", sec_out, 8);

        // R9: unused addresses
        cur_req = "R9";
        wr(3'd0, 32'd0);
        t0 = ns_out;
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        idle(2);
        chk("R9 unused no effect", ns_out, t0);

        // R4: random addend rewrites and restarts in trimmed mode
        cur_req = "R4";
        wr(3'd1, 32'd16);
        wr(3'd0, 32'd1);
        for (int k = 0; k < 60; k++) begin
            wr(3'd2, $urandom);
            idle(40);
            if (k % 15 == 14) begin
                wr(3'd0, 32'd0);
                idle(3);
                wr(3'd0, (k % 30 == 14) ? 32'd3 : 32'd1);
            end
        end
        idle(5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule